// File: doc/BRIEF.md
# Endpoint Packet Retry Controller

This block sits between a USB device protocol engine and the FIFOs of its endpoints. It lets the device recover from failed transactions without help from the local processor. When a packet starts, the block records the FIFO pointer of the side being used, the endpoint number and whether the endpoint is isochronous. When the packet ends, the protocol engine reports success or error, and the block issues exactly one follow-up action to the FIFO and to the status logic.

With retry enabled on a non-isochronous endpoint, a failed IN packet rewinds the FIFO read pointer to the recorded start. The next IN token then sends the same bytes again. A failed OUT packet rewinds the write pointer, so only the bytes of that packet are discarded. Both cases stay hidden from software: no status update, no interrupt and no commit. If retry is disabled or the endpoint is isochronous, an error goes down the normal path instead: the error status is raised and the packet is committed.

The state machine has seven states:
- `ST_IDLE` waits for a packet start. It moves to `ST_IN_PKT` or `ST_OUT_PKT` depending on direction.
- `ST_IN_PKT` and `ST_OUT_PKT` are the packet-in-flight states.
  - On error, they go to `ST_REWIND` (IN) or `ST_DISCARD` (OUT) when retry applies, and to `ST_REPORT` when it does not.
  - On success, they go to `ST_COMMIT`.
- Each of the four action states lasts one cycle and then returns to `ST_IDLE`.

Top module: `ep_retry_ctrl`

## Requirements
- R1: After reset, every action output (`in_rewind`, `out_discard`, `pkt_commit`, `status_ok`, `status_err`) is 0.
- R2: `restore_ptr` and `act_ep` hold the `fifo_ptr` and `ep_sel` values sampled on the clock edge where `pkt_start` is accepted in idle.
- R3: An error (`txn_err`=1) on an IN packet (`dir_in`=1), with `retry_en`=1 and `ep_iso`=0 at the start, pulses `in_rewind` for exactly one cycle, in the cycle after the error edge. No status or commit output is raised. Reading from `restore_ptr` then replays the identical bytes.
- R4: An error on an OUT packet (`dir_in`=0), with retry enabled and a non-isochronous endpoint, pulses `out_discard` for one cycle with `restore_ptr` equal to the write pointer saved at start. No status or commit output is raised.
- R5: `txn_ok` without `txn_err` ends the packet with a one-cycle pulse in which `pkt_commit`=1 and `status_ok`=1.
- R6: With `retry_en`=0 at the error edge, an error pulses `status_err` and `pkt_commit` for one cycle, and no rewind or discard occurs.
- R7: An endpoint flagged isochronous at packet start is never retried. Its errors behave as in R6 even when `retry_en`=1.
- R8: When `txn_ok` and `txn_err` are both high on the same edge, the error takes priority.
- R9: `txn_ok` and `txn_err` in idle are ignored: no action output follows.
- R10: A `pkt_start` while a packet is in flight is ignored. The saved pointer and endpoint are unchanged.
- R11: At most one of `in_rewind`, `out_discard`, `status_ok` and `status_err` is high in any cycle. Each action lasts one cycle, after which a new packet start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retry_en | input | 1 | Automatic retry enable, sampled at the error edge |
| pkt_start | input | 1 | First byte / start of packet strobe |
| dir_in | input | 1 | 1 = IN packet, 0 = OUT packet |
| ep_sel | input | EP_W | Endpoint number of the packet |
| ep_iso | input | 1 | Endpoint is isochronous |
| fifo_ptr | input | PTR_W | Current read (IN) or write (OUT) pointer of the endpoint FIFO |
| txn_ok | input | 1 | Transaction completed with good handshake |
| txn_err | input | 1 | Transaction failed |
| act_ep | output | EP_W | Endpoint the current action applies to |
| restore_ptr | output | PTR_W | Pointer saved at packet start |
| in_rewind | output | 1 | Load `restore_ptr` into the FIFO read pointer |
| out_discard | output | 1 | Load `restore_ptr` into the FIFO write pointer |
| pkt_commit | output | 1 | Release the packet's pointer movement permanently |
| status_ok | output | 1 | Raise success status / interrupt |
| status_err | output | 1 | Raise error status / interrupt |

## Verification
The bench keeps its own byte FIFO and reads a whole IN packet from it. It injects an error, follows the rewind, and compares every replayed byte with the first pass. A design that saved the pointer late or rewound to the wrong place would send shifted data.

Several paths must stay quiet:
- Errors on an isochronous endpoint and errors with retry disabled must reach the status path. A design that ignored the endpoint type would silently retry them.
- Simultaneous success and error strobes must resolve to the error. A design that checked success first would commit a broken packet.
- A stray start in mid-packet must leave the saved pointer alone. A design that overwrote it would rewind only part of the packet.
- Strobes while idle must produce nothing.

// File: rtl/erc_pkg.sv
package erc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IN_PKT,
        ST_OUT_PKT,
        ST_COMMIT,
        ST_REWIND,
        ST_DISCARD,
        ST_REPORT
    } erc_state_t;
endpackage

// File: rtl/erc_snapshot.sv
module erc_snapshot #(
    parameter int PTR_W = 6,
    parameter int EP_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [PTR_W-1:0] ptr_in,
    input  logic [EP_W-1:0]  ep_in,
    input  logic             iso_in,
    output logic [PTR_W-1:0] ptr_q,
    output logic [EP_W-1:0]  ep_q,
    output logic             iso_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            ep_q  <= '0;
            iso_q <= 1'b0;
        end else if (capture) begin
            ptr_q <= ptr_in;
            ep_q  <= ep_in;
            iso_q <= iso_in;
        end
    end
endmodule

// File: rtl/erc_fsm.sv
module erc_fsm
    import erc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_in,
    input  logic ok,
    input  logic err,
    input  logic retry_en,
    input  logic iso_saved,
    output logic capture,
    output logic do_rewind,
    output logic do_discard,
    output logic do_commit,
    output logic rep_ok,
    output logic rep_err
);
    erc_state_t state, state_nx;
    logic       may_retry;

    assign may_retry = retry_en && !iso_saved;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) state_nx = is_in ? ST_IN_PKT : ST_OUT_PKT;
            end
            ST_IN_PKT: begin
                if (err)     state_nx = may_retry ? ST_REWIND : ST_REPORT;
                else if (ok) state_nx = ST_COMMIT;
            end
            ST_OUT_PKT: begin
                if (err)     state_nx = may_retry ? ST_DISCARD : ST_REPORT;
                else if (ok) state_nx = ST_COMMIT;
            end
            ST_COMMIT, ST_REWIND, ST_DISCARD, ST_REPORT: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        capture    = 1'b0;
        do_rewind  = 1'b0;
        do_discard = 1'b0;
        do_commit  = 1'b0;
        rep_ok     = 1'b0;
        rep_err    = 1'b0;
        unique case (state)
            ST_IDLE:    capture = start;
            ST_COMMIT:  begin do_commit = 1'b1; rep_ok = 1'b1; end
            ST_REWIND:  do_rewind = 1'b1;
            ST_DISCARD: do_discard = 1'b1;
            ST_REPORT:  begin do_commit = 1'b1; rep_err = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/ep_retry_ctrl.sv
module ep_retry_ctrl #(
    parameter int PTR_W = 6,
    parameter int EP_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retry_en,
    input  logic             pkt_start,
    input  logic             dir_in,
    input  logic [EP_W-1:0]  ep_sel,
    input  logic             ep_iso,
    input  logic [PTR_W-1:0] fifo_ptr,
    input  logic             txn_ok,
    input  logic             txn_err,
    output logic [EP_W-1:0]  act_ep,
    output logic [PTR_W-1:0] restore_ptr,
    output logic             in_rewind,
    output logic             out_discard,
    output logic             pkt_commit,
    output logic             status_ok,
    output logic             status_err
);
    logic capture;
    logic iso_saved;

    erc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (pkt_start),
        .is_in     (dir_in),
        .ok        (txn_ok),
        .err       (txn_err),
        .retry_en  (retry_en),
        .iso_saved (iso_saved),
        .capture   (capture),
        .do_rewind (in_rewind),
        .do_discard(out_discard),
        .do_commit (pkt_commit),
        .rep_ok    (status_ok),
        .rep_err   (status_err)
    );

    erc_snapshot #(.PTR_W(PTR_W), .EP_W(EP_W)) u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(capture),
        .ptr_in (fifo_ptr),
        .ep_in  (ep_sel),
        .iso_in (ep_iso),
        .ptr_q  (restore_ptr),
        .ep_q   (act_ep),
        .iso_q  (iso_saved)
    );
endmodule

// File: rtl/ep_retry_chk.sv
module ep_retry_chk (
    input logic clk,
    input logic rst_n,
    input logic retry_en,
    input logic txn_ok,
    input logic txn_err,
    input logic in_rewind,
    input logic out_discard,
    input logic pkt_commit,
    input logic status_ok,
    input logic status_err
);
    a_r11_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({in_rewind, out_discard, status_ok, status_err}));

    a_r3_rewind_silent: assert property (@(posedge clk) disable iff (!rst_n)
        in_rewind |-> !status_ok && !status_err && !pkt_commit);

    a_r4_discard_silent: assert property (@(posedge clk) disable iff (!rst_n)
        out_discard |-> !status_ok && !status_err && !pkt_commit);

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rewind || out_discard || pkt_commit) |=> !(in_rewind || out_discard || pkt_commit));

    a_r5_ok_from_ok: assert property (@(posedge clk) disable iff (!rst_n)
        status_ok |-> $past(txn_ok) && !$past(txn_err));

    a_r6_retry_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rewind || out_discard) |-> $past(retry_en) && $past(txn_err));

    a_r6_err_needs_err: assert property (@(posedge clk) disable iff (!rst_n)
        status_err |-> $past(txn_err) && pkt_commit);
endmodule

bind ep_retry_ctrl ep_retry_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .retry_en   (retry_en),
    .txn_ok     (txn_ok),
    .txn_err    (txn_err),
    .in_rewind  (in_rewind),
    .out_discard(out_discard),
    .pkt_commit (pkt_commit),
    .status_ok  (status_ok),
    .status_err (status_err)
);

// File: tb/sim_ep_retry_ctrl.sv
module sim_ep_retry_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PTR_W = 6;
    localparam int EP_W  = 3;
    localparam int DEPTH = 1 << PTR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic retry_en = 1'b0, pkt_start = 1'b0, dir_in = 1'b0, ep_iso = 1'b0;
    logic txn_ok = 1'b0, txn_err = 1'b0;
    logic [EP_W-1:0]  ep_sel = '0;
    logic [PTR_W-1:0] fifo_ptr = '0;
    logic [EP_W-1:0]  act_ep;
    logic [PTR_W-1:0] restore_ptr;
    logic in_rewind, out_discard, pkt_commit, status_ok, status_err;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] fifo_mem [DEPTH];
    logic [PTR_W-1:0] rd_model;

    always #(CLK_PERIOD/2) clk = ~clk;

    ep_retry_ctrl #(.PTR_W(PTR_W), .EP_W(EP_W)) u0 (
        .clk(clk), .rst_n(rst_n), .retry_en(retry_en), .pkt_start(pkt_start),
        .dir_in(dir_in), .ep_sel(ep_sel), .ep_iso(ep_iso), .fifo_ptr(fifo_ptr),
        .txn_ok(txn_ok), .txn_err(txn_err), .act_ep(act_ep),
        .restore_ptr(restore_ptr), .in_rewind(in_rewind), .out_discard(out_discard),
        .pkt_commit(pkt_commit), .status_ok(status_ok), .status_err(status_err)
    );

    task automatic check(input bit good, input string req, input int act, input int exp);
        n_checks++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int acts();
        return {27'd0, in_rewind, out_discard, pkt_commit, status_ok, status_err};
    endfunction

    task automatic begin_pkt(input logic d, input int ep, input logic iso, input int p);
        pkt_start = 1'b1; dir_in = d; ep_sel = EP_W'(ep); ep_iso = iso;
        fifo_ptr = PTR_W'(p);
        step();
        pkt_start = 1'b0;
    endtask

    task automatic end_pkt(input logic ok, input logic err);
        txn_ok = ok; txn_err = err;
        step();
        txn_ok = 1'b0; txn_err = 1'b0;
    endtask

    task automatic t_reset();
        check(acts() == 0, "R1 idle outputs", acts(), 0);
    endtask

    task automatic t_in_ok();
        retry_en = 1'b1;
        begin_pkt(1'b1, 2, 1'b0, 5);
        step();
        end_pkt(1'b1, 1'b0);
        check(restore_ptr == 5 && act_ep == 2, "R2 snapshot", int'(restore_ptr), 5);
        check(acts() == 5'b00110, "R5 commit+ok", acts(), 5'b00110);
        step();
        check(acts() == 0, "R11 single cycle", acts(), 0);
    endtask

    task automatic t_in_replay();
        logic [7:0] first [8];
        retry_en = 1'b1;
        rd_model = 6'd20;
        begin_pkt(1'b1, 1, 1'b0, int'(rd_model));
        for (int i = 0; i < 8; i++) begin
            first[i] = fifo_mem[rd_model];
            rd_model++;
            step();
        end
        end_pkt(1'b0, 1'b1);
        check(acts() == 5'b10000, "R3 rewind only", acts(), 5'b10000);
        check(act_ep == 1, "R3 endpoint", int'(act_ep), 1);
        if (in_rewind) rd_model = restore_ptr;
        step();
        check(acts() == 0, "R11 rewind one cycle", acts(), 0);
        begin_pkt(1'b1, 1, 1'b0, int'(rd_model));
        for (int i = 0; i < 8; i++) begin
            check(fifo_mem[rd_model] == first[i], "R3 replay byte",
                  int'(fifo_mem[rd_model]), int'(first[i]));
            rd_model++;
        end
        end_pkt(1'b1, 1'b0);
        check(status_ok == 1'b1, "R5 replay ok", int'(status_ok), 1);
        step();
    endtask

    task automatic t_out_discard();
        retry_en = 1'b1;
        begin_pkt(1'b0, 3, 1'b0, 41);
        step(); step();
        end_pkt(1'b0, 1'b1);
        check(acts() == 5'b01000, "R4 discard only", acts(), 5'b01000);
        check(restore_ptr == 41, "R4 saved wr ptr", int'(restore_ptr), 41);
        step();
    endtask

    task automatic t_no_retry();
        retry_en = 1'b0;
        begin_pkt(1'b1, 4, 1'b0, 9);
        end_pkt(1'b0, 1'b1);
        check(acts() == 5'b00101, "R6 in err path", acts(), 5'b00101);
        step();
        begin_pkt(1'b0, 4, 1'b0, 9);
        end_pkt(1'b0, 1'b1);
        check(acts() == 5'b00101, "R6 out err path", acts(), 5'b00101);
        step();
    endtask

    task automatic t_iso();
        retry_en = 1'b1;
        begin_pkt(1'b1, 2, 1'b1, 12);
        ep_iso = 1'b0;
        end_pkt(1'b0, 1'b1);
        check(acts() == 5'b00101, "R7 iso in", acts(), 5'b00101);
        step();
        begin_pkt(1'b0, 2, 1'b1, 12);
        end_pkt(1'b0, 1'b1);
        check(acts() == 5'b00101, "R7 iso out", acts(), 5'b00101);
        step();
    endtask

    task automatic t_both();
        retry_en = 1'b1;
        begin_pkt(1'b1, 1, 1'b0, 30);
        end_pkt(1'b1, 1'b1);
        check(acts() == 5'b10000, "R8 error priority", acts(), 5'b10000);
        step();
    endtask

    task automatic t_idle_strobes();
        retry_en = 1'b1;
        end_pkt(1'b1, 1'b0);
        check(acts() == 0, "R9 idle ok ignored", acts(), 0);
        end_pkt(1'b0, 1'b1);
        check(acts() == 0, "R9 idle err ignored", acts(), 0);
    endtask

    task automatic t_restart();
        retry_en = 1'b1;
        begin_pkt(1'b0, 5, 1'b0, 17);
        begin_pkt(1'b1, 6, 1'b1, 50);
        check(restore_ptr == 17 && act_ep == 5, "R10 snapshot held", int'(restore_ptr), 17);
        end_pkt(1'b0, 1'b1);
        check(acts() == 5'b01000, "R10 still out packet", acts(), 5'b01000);
        step();
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) fifo_mem[i] = 8'((i * 37 + 11) ^ (i >> 2));
        step(); step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_in_ok();
        t_in_replay();
        t_out_discard();
        t_no_retry();
        t_iso();
        t_both();
        t_idle_strobes();
        t_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule